// File: doc/BRIEF.md
# Next-PC generation unit

This unit holds the program counter of a single-cycle processor core and computes the address of the following instruction on every clock edge. The address is chosen from three candidates. The first is the sequential address, which is the current PC plus four. The second is a PC-relative branch target. The third is a pseudo-direct jump target built from the upper PC bits and an index taken from the instruction. The decoder supplies the branch displacement, the jump index and three strobes: branch-if-equal, branch-if-not-equal and jump. The ALU supplies its zero flag, which settles whether a branch is taken.

The branch target adds the sequential sum PC+4, which fetch computes anyway, to the displacement after sign extension and a left shift of two. The shift turns a word offset into a byte offset. The jump target keeps the top four bits of the current PC, appends the 26-bit index, and ends in two zero bits. A jump wins over any branch strobe raised in the same cycle. The register resets synchronously to zero.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `pc` becomes 0 on that edge, whatever the other inputs are.
- R2: With `jump`, `branchEq` and `branchNe` all 0, `pc` advances by 4 on every rising edge.
- R3: With `branchEq` 1, `aluZero` 1 and `jump` 0, the next `pc` is the old `pc` + 4 + (sign-extended `brDisp` shifted left by 2).
- R4: With `branchEq` 1 and `aluZero` 0 (no other strobe), the next `pc` is the old `pc` + 4.
- R5: With `branchNe` 1 and `jump` 0, the branch target is taken when `aluZero` is 0, and the next `pc` is the old `pc` + 4 when `aluZero` is 1.
- R6: `brDisp` is a two's complement word count: bit 15 set moves the target backwards (for example 16'hFFFC gives old `pc` + 4 − 16).
- R7: With `jump` 1, the next `pc` is {old `pc`[31:28], `jmpIdx`, 2'b00}.
- R8: When `jump` and a taken branch are asserted together, the jump target is used.
- R9: All additions wrap modulo 2^32; from `pc` = 32'hFFFFFFFC a sequential step gives 0.
- R10: `pc`[1:0] is always 2'b00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC register updates on every rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branchEq | input | 1 | Branch strobe taken on a zero ALU result |
| branchNe | input | 1 | Branch strobe taken on a nonzero ALU result |
| jump | input | 1 | Pseudo-direct jump strobe from the opcode decoder |
| aluZero | input | 1 | ALU zero flag of the current compare |
| brDisp | input | 16 | Signed branch displacement in words |
| jmpIdx | input | 26 | Word index of the jump target |
| pc | output | 32 | Current program counter value |

## Verification
The bench runs each branch strobe with both polarities of the zero flag. A design that swapped the sense of the flag, or ignored one strobe, would step sequentially where it should branch, or branch where it should step. It uses negative displacements, including one that lands on 32'hFFFFFFFC and then wraps to zero. A design that zero-extends the displacement or forgets the shift would land far off or on a misaligned address. Jumps are made both from a PC whose top nibble is 0 and from one whose top nibble is F, so a target that drops or misplaces those bits shows up. A jump raised together with a taken branch, and a reset raised together with a jump, show whether the priority order is right.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef struct packed {
    logic useJump;
    logic useBranch;
  } pcSel_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic   branchEq,
  input  logic   branchNe,
  input  logic   jump,
  input  logic   aluZero,
  output pcSel_t sel
);

  logic eqTaken;
  logic neTaken;

  always_comb begin
    eqTaken       = branchEq & aluZero;
    neTaken       = branchNe & ~aluZero;
    sel.useJump   = jump;
    sel.useBranch = ~jump & (eqTaken | neTaken);
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  pcSel_t            sel,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [IDX_W-1:0]  jmpIdx,
  output logic [ADDR_W-1:0] pc
);

  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam int HI_W  = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] dispBytes;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpTarget;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    pcPlus4   = pcQ + STEP;
    dispBytes = {{EXT_W{brDisp[DISP_W-1]}}, brDisp, 2'b00};
    brTarget  = pcPlus4 + dispBytes;
    jmpTarget = {pcQ[ADDR_W-1 -: HI_W], jmpIdx, 2'b00};
    if (sel.useJump)        pcNext = jmpTarget;
    else if (sel.useBranch) pcNext = brTarget;
    else                    pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign pc = pcQ;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branchEq,
  input  logic              branchNe,
  input  logic              jump,
  input  logic              aluZero,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [IDX_W-1:0]  jmpIdx,
  output logic [ADDR_W-1:0] pc
);

  pcSel_t sel;

  npc_ctrl i_ctrl (
    .branchEq (branchEq),
    .branchNe (branchNe),
    .jump     (jump),
    .aluZero  (aluZero),
    .sel      (sel)
  );

  npc_datapath #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .IDX_W  (IDX_W)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .brDisp (brDisp),
    .jmpIdx (jmpIdx),
    .pc     (pc)
  );

endmodule

// File: rtl/npc_checks.sv
module npc_checks #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              branchEq,
  input logic              branchNe,
  input logic              jump,
  input logic              aluZero,
  input logic [DISP_W-1:0] brDisp,
  input logic [IDX_W-1:0]  jmpIdx,
  input logic [ADDR_W-1:0] pc
);

  localparam int HI_W = ADDR_W - IDX_W - 2;

  a_r1_sync_reset: assert property (@(posedge clk) rst |=> pc == '0);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jump && !branchEq && !branchNe) |=> pc == $past(pc) + ADDR_W'(4));

  a_r4_beq_not_taken: assert property (@(posedge clk) disable iff (rst)
    (branchEq && !branchNe && !aluZero && !jump) |=> pc == $past(pc) + ADDR_W'(4));

  a_r5_bne_not_taken: assert property (@(posedge clk) disable iff (rst)
    (branchNe && !branchEq && aluZero && !jump) |=> pc == $past(pc) + ADDR_W'(4));

  // R7 and R8: the jump target wins over any branch strobe
  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == {$past(pc[ADDR_W-1 -: HI_W]), $past(jmpIdx), 2'b00});

  a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_checks #(
  .ADDR_W (ADDR_W),
  .DISP_W (DISP_W),
  .IDX_W  (IDX_W)
) i_npc_checks (.*);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

  typedef struct {
    logic [31:0] expPc;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchEq = 1'b0;
  logic        branchNe = 1'b0;
  logic        jump = 1'b0;
  logic        aluZero = 1'b0;
  logic [15:0] brDisp = '0;
  logic [25:0] jmpIdx = '0;
  logic [31:0] pc;

  item_t       sbQ[$];
  logic [31:0] model = '0;
  int          runCnt = 0;
  int          failCnt = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .branchEq(branchEq), .branchNe(branchNe),
    .jump(jump), .aluZero(aluZero), .brDisp(brDisp), .jmpIdx(jmpIdx), .pc(pc)
  );

  task automatic step(input logic r, input logic beq, input logic bne,
                      input logic jmp, input logic z, input logic [15:0] d,
                      input logic [25:0] idx, input string tag);
    item_t it;
    logic [31:0] seqAddr;
    logic taken;
    @(negedge clk);
    rst = r; branchEq = beq; branchNe = bne; jump = jmp; aluZero = z;
    brDisp = d; jmpIdx = idx;
    seqAddr = model + 32'd4;
    taken = (beq && z) || (bne && !z);
    if (r)        model = 32'd0;
    else if (jmp) model = {model[31:28], idx, 2'b00};
    else if (taken) model = seqAddr + {{14{d[15]}}, d, 2'b00};
    else          model = seqAddr;
    it.expPc = model;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (sbQ.size() > 0) begin
      it = sbQ.pop_front();
      runCnt++;
      if (pc !== it.expPc) begin
        failCnt++;
        $display("FAIL %s: pc actual %h expected %h", it.tag, pc, it.expPc);
      end
      runCnt++;
      if (pc[1:0] !== 2'b00) begin
        failCnt++;
        $display("FAIL R10: pc[1:0] actual %b expected 00", pc[1:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog: cycles actual %0d expected below 5000", cycles);
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, 16'h0, 26'h0, "R1");
    step(1, 0, 0, 0, 0, 16'h0, 26'h0, "R1");
    step(0, 0, 0, 0, 0, 16'h0, 26'h0, "R2");            // 4
    step(0, 0, 0, 0, 1, 16'h7, 26'h5, "R2");            // 8
    step(0, 1, 0, 0, 0, 16'h5, 26'h0, "R4");            // 12
    step(0, 1, 0, 0, 1, 16'h3, 26'h0, "R3");            // 28
    step(0, 0, 1, 0, 1, 16'h3, 26'h0, "R5");            // 32
    step(0, 0, 1, 0, 0, 16'h1, 26'h0, "R5");            // 40
    step(0, 0, 0, 1, 0, 16'h9, 26'h123, "R7");          // 0x48C
    step(0, 1, 0, 1, 1, 16'd100, 26'h10, "R8");         // 0x40
    step(0, 0, 1, 1, 0, 16'd50, 26'h20, "R8");          // 0x80
    step(0, 1, 0, 0, 1, 16'hFFFC, 26'h0, "R6");         // 0x74
    step(0, 0, 0, 1, 0, 16'h0, 26'h0, "R7");            // 0
    step(0, 1, 0, 0, 1, 16'hFFFE, 26'h0, "R6");         // 0xFFFFFFFC
    step(0, 0, 0, 0, 0, 16'h0, 26'h0, "R9");            // 0
    step(0, 0, 1, 0, 0, 16'hFFFE, 26'h0, "R6");         // 0xFFFFFFFC
    step(0, 0, 0, 1, 1, 16'h0, 26'h1, "R7");            // 0xF0000004
    step(0, 0, 0, 0, 0, 16'h0, 26'h0, "R2");            // 0xF0000008
    step(0, 1, 1, 0, 1, 16'h2, 26'h0, "R3");            // 0xF0000014
    step(1, 1, 0, 1, 1, 16'h8, 26'h3FF, "R1");          // 0
    step(0, 0, 0, 0, 0, 16'h0, 26'h0, "R2");            // 4
    @(negedge clk);
    rst = 0; branchEq = 0; branchNe = 0; jump = 0;
    wait (sbQ.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

endmodule